// File: doc/BRIEF.md
# Display Channel Status and Interrupt Aggregator

This block gathers the status of up to three display output channels of a compositor and turns their error and event indications into interrupt lines. Each channel supplies its operating mode, its FIFO full and empty flags, its current output line and a set of strobes from the compositing datapath. The strobes are frame start, line start, a level meaning the current output line still holds pixels, FIFO reads and line completion. The block watches these signals, keeps a sticky bit for each error or event, counts frames, and gates the sticky bits through per-channel enables to make one interrupt per channel.

A separate group records errors from the block's bus master and bus slave ports. It keeps the most recent 2-bit bus response and sets sticky DMA, slave-read-decode and slave-write-decode interrupt bits. One clear strobe wipes every sticky bit and the stored response in a single cycle. All channel interrupts and bus interrupts are ORed into one top-level interrupt line.

All interfaces are plain level or strobe signals sampled on the rising clock edge. No interface carries a data stream, so none has back-pressure. Sticky bits and the frame counter change one cycle after the event that sets them. The interrupt lines and the status word are combinational views of that registered state and of the current inputs.

Top module: `disp_stat_irq`

## Requirements
- R1: After reset every sticky bit is 0, every frame count is 0, the stored bus response is 0 (OKAY), and every interrupt output is 0 while the enables are 0.
- R2: A channel's short-frame bit is set in the cycle after `frm_start` is high while `pix_left` is high for that channel.
- R3: A channel's short-line bit is set in the cycle after `ln_start` is high while `pix_left` is high for that channel.
- R4: A channel's underflow bit is set in the cycle after `fifo_rd` is high while `fifo_empty` is high for that channel.
- R5: The mode is encoded as 0 disabled, 1 init, 2 run and 3 end-of-frame. A channel's end-of-frame bit is set, and its 6-bit frame count is incremented modulo 64, in the cycle after its mode input changes from 2 in one cycle to 3 in the next. The frame count is not affected by the clear strobe.
- R6: A channel's end-of-line-N bit is set in the cycle after `line_done` is high while that channel's `line_num` equals `eoln_line`.
- R7: `ch_irq[c]` is `en_ch[c]` AND (short-frame OR (`en_err[c]` AND (short-line OR underflow)) OR (`en_eof[c]` AND end-of-frame) OR (`en_eoln[c]` AND end-of-line-N)). Short-frame has no enable of its own.
- R8: When `bresp_vld` is high, `bresp` is stored in `resp_q` on the next edge. `dma_irq` is set when `dma_id_err` is high, or when `bresp_vld` is high with a nonzero response (1 EXOKAY, 2 SLVERR, 3 DECERR).
- R9: `rd_dec_irq` and `wr_dec_irq` are sticky bits set by `slv_rd_err` and `slv_wr_err`.
- R10: All sticky bits hold until `clr_all`. A high `clr_all` clears every sticky bit and `resp_q` on the next edge. An event in the same cycle as the clear still sets its bit, and a new response strobe still loads `resp_q`.
- R11: `chan_word` holds 22 bits per channel, with channel c in bits [22c+21:22c]. The fields are: [11:0] current line, [17:12] frame count, [18] FIFO empty, [19] FIFO full, [21:20] mode.
- R12: `irq` is the OR of every `ch_irq` bit together with `dma_irq`, `rd_dec_irq` and `wr_dec_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_in | input | 6 | Per-channel mode, 2 bits each |
| frm_start | input | 3 | Per-channel frame-start strobe |
| ln_start | input | 3 | Per-channel line-start strobe |
| pix_left | input | 3 | Current output line still holds pixels |
| fifo_rd | input | 3 | Downstream FIFO read strobe |
| fifo_empty | input | 3 | FIFO empty flag |
| fifo_full | input | 3 | FIFO full flag |
| line_done | input | 3 | Line finished compositing |
| line_num | input | 36 | Per-channel current line, 12 bits each |
| eoln_line | input | 12 | Programmed line number for the end-of-line-N event |
| en_eof | input | 3 | End-of-frame interrupt enable |
| en_eoln | input | 3 | End-of-line-N interrupt enable |
| en_err | input | 3 | Short-line and underflow interrupt enable |
| en_ch | input | 3 | Per-channel master interrupt enable |
| dma_id_err | input | 1 | Invalid DMA ID error strobe |
| bresp_vld | input | 1 | Bus response capture strobe |
| bresp | input | 2 | Bus response code |
| slv_rd_err | input | 1 | Slave read decode error strobe |
| slv_wr_err | input | 1 | Slave write decode error strobe |
| clr_all | input | 1 | Clear all sticky status |
| st_eof | output | 3 | Sticky end-of-frame bits |
| st_eoln | output | 3 | Sticky end-of-line-N bits |
| st_sfrm | output | 3 | Sticky short-frame bits |
| st_sline | output | 3 | Sticky short-line bits |
| st_uflow | output | 3 | Sticky underflow bits |
| ch_irq | output | 3 | Per-channel interrupts |
| chan_word | output | 66 | Per-channel status words |
| resp_q | output | 2 | Stored bus response |
| dma_irq | output | 1 | Sticky DMA interrupt |
| rd_dec_irq | output | 1 | Sticky slave read decode interrupt |
| wr_dec_irq | output | 1 | Sticky slave write decode interrupt |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives the frame counter through more than 64 run-to-end transitions on one channel. A counter that misses the wrap, or counts entry into end-of-frame from any mode other than run, drifts away from the reference. Random traffic puts clear strobes in the same cycle as events and as response strobes. A design where the clear wins loses those events, and one that does not clear `resp_q` leaves a stale error response behind. The enable mix covers short-frame with every enable off, which exposes a design that gates it, and underflow raised with only the short-line enable, which exposes a design that gives underflow its own enable.

// File: rtl/disp_stat_pkg.sv
package disp_stat_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_INIT = 2'd1,
    MODE_RUN  = 2'd2,
    MODE_EOF  = 2'd3
  } chan_mode_e;

  localparam logic [1:0] RESP_OKAY = 2'd0;
endpackage

// File: rtl/disp_stat_chan.sv
module disp_stat_chan #(
  parameter int LINE_W = 12,
  parameter int FCNT_W = 6,
  localparam int WORD_W = 4 + FCNT_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              frm_start,
  input  logic              ln_start,
  input  logic              pix_left,
  input  logic              fifo_rd,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic              line_done,
  input  logic [LINE_W-1:0] line_num,
  input  logic [LINE_W-1:0] eoln_line,
  input  logic              en_eof,
  input  logic              en_eoln,
  input  logic              en_err,
  input  logic              en_ch,
  input  logic              clr,
  output logic              s_eof,
  output logic              s_eoln,
  output logic              s_sfrm,
  output logic              s_sline,
  output logic              s_uflow,
  output logic              irq,
  output logic [WORD_W-1:0] word
);
  import disp_stat_pkg::*;

  chan_mode_e        mode_prev;
  logic [FCNT_W-1:0] fcnt;
  logic [4:0]        sticky, set_v;
  logic              eof_evt;

  assign eof_evt = (mode_prev == MODE_RUN) && (chan_mode_e'(mode) == MODE_EOF);
  assign set_v   = {eof_evt,
                    line_done && (line_num == eoln_line),
                    frm_start && pix_left,
                    ln_start && pix_left,
                    fifo_rd && fifo_empty};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_prev <= MODE_OFF;
      fcnt      <= '0;
      sticky    <= '0;
    end else begin
      mode_prev <= chan_mode_e'(mode);
      if (eof_evt) fcnt <= fcnt + 1'b1;
      sticky <= (clr ? 5'd0 : sticky) | set_v;
    end
  end

  assign {s_eof, s_eoln, s_sfrm, s_sline, s_uflow} = sticky;
  assign irq  = en_ch && (s_sfrm || (en_err && (s_sline || s_uflow)) ||
                          (en_eof && s_eof) || (en_eoln && s_eoln));
  assign word = {mode, fifo_full, fifo_empty, fcnt, line_num};

  // R2
  sfrm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && pix_left) |=> s_sfrm);
  // R3
  sline_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_start && pix_left) |=> s_sline);
  // R4
  uflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && fifo_empty) |=> s_uflow);
  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (($past({s_eof, s_eoln, s_sfrm, s_sline, s_uflow}) &
               ~{s_eof, s_eoln, s_sfrm, s_sline, s_uflow}) == 5'd0));
endmodule

// File: rtl/disp_stat_bus.sv
module disp_stat_bus (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dma_id_err,
  input  logic       bresp_vld,
  input  logic [1:0] bresp,
  input  logic       slv_rd_err,
  input  logic       slv_wr_err,
  input  logic       clr,
  output logic [1:0] resp_q,
  output logic       dma_irq,
  output logic       rd_dec_irq,
  output logic       wr_dec_irq
);
  import disp_stat_pkg::*;

  logic dma_set;
  assign dma_set = dma_id_err || (bresp_vld && (bresp != RESP_OKAY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_q     <= RESP_OKAY;
      dma_irq    <= 1'b0;
      rd_dec_irq <= 1'b0;
      wr_dec_irq <= 1'b0;
    end else begin
      if (bresp_vld)  resp_q <= bresp;
      else if (clr)   resp_q <= RESP_OKAY;
      dma_irq    <= (dma_irq && !clr) || dma_set;
      rd_dec_irq <= (rd_dec_irq && !clr) || slv_rd_err;
      wr_dec_irq <= (wr_dec_irq && !clr) || slv_wr_err;
    end
  end

  // R8
  dma_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_id_err |=> dma_irq);
  // R8
  resp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bresp_vld |=> (resp_q == $past(bresp)));
  // R9
  rd_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_rd_err |=> rd_dec_irq);
endmodule

// File: rtl/disp_stat_irq.sv
module disp_stat_irq #(
  parameter int NCH    = 3,
  parameter int LINE_W = 12,
  parameter int FCNT_W = 6,
  localparam int WORD_W = 4 + FCNT_W + LINE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NCH-1:0]      mode_in,
  input  logic [NCH-1:0]        frm_start,
  input  logic [NCH-1:0]        ln_start,
  input  logic [NCH-1:0]        pix_left,
  input  logic [NCH-1:0]        fifo_rd,
  input  logic [NCH-1:0]        fifo_empty,
  input  logic [NCH-1:0]        fifo_full,
  input  logic [NCH-1:0]        line_done,
  input  logic [LINE_W*NCH-1:0] line_num,
  input  logic [LINE_W-1:0]     eoln_line,
  input  logic [NCH-1:0]        en_eof,
  input  logic [NCH-1:0]        en_eoln,
  input  logic [NCH-1:0]        en_err,
  input  logic [NCH-1:0]        en_ch,
  input  logic                  dma_id_err,
  input  logic                  bresp_vld,
  input  logic [1:0]            bresp,
  input  logic                  slv_rd_err,
  input  logic                  slv_wr_err,
  input  logic                  clr_all,
  output logic [NCH-1:0]        st_eof,
  output logic [NCH-1:0]        st_eoln,
  output logic [NCH-1:0]        st_sfrm,
  output logic [NCH-1:0]        st_sline,
  output logic [NCH-1:0]        st_uflow,
  output logic [NCH-1:0]        ch_irq,
  output logic [WORD_W*NCH-1:0] chan_word,
  output logic [1:0]            resp_q,
  output logic                  dma_irq,
  output logic                  rd_dec_irq,
  output logic                  wr_dec_irq,
  output logic                  irq
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    disp_stat_chan #(.LINE_W(LINE_W), .FCNT_W(FCNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .mode(mode_in[2*c +: 2]),
      .frm_start(frm_start[c]), .ln_start(ln_start[c]), .pix_left(pix_left[c]),
      .fifo_rd(fifo_rd[c]), .fifo_empty(fifo_empty[c]), .fifo_full(fifo_full[c]),
      .line_done(line_done[c]), .line_num(line_num[LINE_W*c +: LINE_W]),
      .eoln_line(eoln_line),
      .en_eof(en_eof[c]), .en_eoln(en_eoln[c]), .en_err(en_err[c]), .en_ch(en_ch[c]),
      .clr(clr_all),
      .s_eof(st_eof[c]), .s_eoln(st_eoln[c]), .s_sfrm(st_sfrm[c]),
      .s_sline(st_sline[c]), .s_uflow(st_uflow[c]),
      .irq(ch_irq[c]), .word(chan_word[WORD_W*c +: WORD_W])
    );
  end

  disp_stat_bus u_bus (
    .clk(clk), .rst_n(rst_n),
    .dma_id_err(dma_id_err), .bresp_vld(bresp_vld), .bresp(bresp),
    .slv_rd_err(slv_rd_err), .slv_wr_err(slv_wr_err), .clr(clr_all),
    .resp_q(resp_q), .dma_irq(dma_irq),
    .rd_dec_irq(rd_dec_irq), .wr_dec_irq(wr_dec_irq)
  );

  assign irq = (|ch_irq) || dma_irq || rd_dec_irq || wr_dec_irq;

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq) |-> (ch_irq == '0 && !dma_irq));
endmodule

// File: tb/sim_disp_stat_irq.sv
module sim_disp_stat_irq;
  localparam int NCH = 3;
  localparam int LW  = 12;
  localparam int WW  = 22;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [2*NCH-1:0] mode_in = '0;
  logic [NCH-1:0] frm_start = '0, ln_start = '0, pix_left = '0, fifo_rd = '0,
                  fifo_empty = '0, fifo_full = '0, line_done = '0,
                  en_eof = '0, en_eoln = '0, en_err = '0, en_ch = '0;
  logic [LW*NCH-1:0] line_num = '0;
  logic [LW-1:0] eoln_line = 12'd2;
  logic dma_id_err = 0, bresp_vld = 0, slv_rd_err = 0, slv_wr_err = 0, clr_all = 0;
  logic [1:0] bresp = '0;
  logic [NCH-1:0] st_eof, st_eoln, st_sfrm, st_sline, st_uflow, ch_irq;
  logic [WW*NCH-1:0] chan_word;
  logic [1:0] resp_q;
  logic dma_irq, rd_dec_irq, wr_dec_irq, irq;

  disp_stat_irq u0 (.*);

  int checks = 0, errors = 0;
  int m_eof[NCH], m_eoln[NCH], m_sfrm[NCH], m_sline[NCH], m_uflow[NCH];
  int m_fcnt[NCH], m_prev[NCH];
  int m_resp, m_dma, m_rd, m_wr;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_eof[c] = 0; m_eoln[c] = 0; m_sfrm[c] = 0; m_sline[c] = 0; m_uflow[c] = 0;
        m_fcnt[c] = 0; m_prev[c] = 0;
      end
      m_resp = 0; m_dma = 0; m_rd = 0; m_wr = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int md;
        bit ev;
        md = int'(mode_in[2*c +: 2]);
        ev = (m_prev[c] == 2) && (md == 3);
        if (clr_all) begin
          m_eof[c] = 0; m_eoln[c] = 0; m_sfrm[c] = 0; m_sline[c] = 0; m_uflow[c] = 0;
        end
        if (ev) begin m_eof[c] = 1; m_fcnt[c] = (m_fcnt[c] + 1) % 64; end
        if (line_done[c] && line_num[LW*c +: LW] == eoln_line) m_eoln[c] = 1;
        if (frm_start[c] && pix_left[c]) m_sfrm[c] = 1;
        if (ln_start[c] && pix_left[c]) m_sline[c] = 1;
        if (fifo_rd[c] && fifo_empty[c]) m_uflow[c] = 1;
        m_prev[c] = md;
      end
      if (clr_all) begin m_dma = 0; m_rd = 0; m_wr = 0; m_resp = 0; end
      if (bresp_vld) m_resp = int'(bresp);
      if (dma_id_err || (bresp_vld && bresp != 2'd0)) m_dma = 1;
      if (slv_rd_err) m_rd = 1;
      if (slv_wr_err) m_wr = 1;
    end
  end

  task automatic compare_all();
    int any;
    any = 0;
    for (int c = 0; c < NCH; c++) begin
      int e, w;
      chk("R5", "eof", int'(st_eof[c]), m_eof[c]);
      chk("R6", "eoln", int'(st_eoln[c]), m_eoln[c]);
      chk("R2", "short_frame", int'(st_sfrm[c]), m_sfrm[c]);
      chk("R3", "short_line", int'(st_sline[c]), m_sline[c]);
      chk("R4", "underflow", int'(st_uflow[c]), m_uflow[c]);
      e = int'(en_ch[c]) & (m_sfrm[c] | (int'(en_err[c]) & (m_sline[c] | m_uflow[c])) |
                            (int'(en_eof[c]) & m_eof[c]) | (int'(en_eoln[c]) & m_eoln[c]));
      chk("R7", "ch_irq", int'(ch_irq[c]), e);
      any |= e;
      w = int'(line_num[LW*c +: LW]) | (m_fcnt[c] << 12) | (int'(fifo_empty[c]) << 18) |
          (int'(fifo_full[c]) << 19) | (int'(mode_in[2*c +: 2]) << 20);
      chk("R11", "chan_word", int'(chan_word[WW*c +: WW]), w);
    end
    chk("R8", "resp_q", int'(resp_q), m_resp);
    chk("R8", "dma_irq", int'(dma_irq), m_dma);
    chk("R9", "rd_dec", int'(rd_dec_irq), m_rd);
    chk("R9", "wr_dec", int'(wr_dec_irq), m_wr);
    chk("R12", "irq", int'(irq), any | m_dma | m_rd | m_wr);
  endtask

  // compare on every falling edge once out of reset
  always @(negedge clk) if (rst_n) compare_all();

  function automatic logic [NCH-1:0] rb(int pct);
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = (($urandom % 100) < pct);
    return v;
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state, all enables off
    chk("R1", "st_sfrm", int'(st_sfrm), 0);
    chk("R1", "resp_q", int'(resp_q), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "fcnt0", int'(chan_word[17:12]), 0);
    // R5 directed: 70 run-to-end transitions on channel 0 wrap the count
    for (int i = 0; i < 140; i++) begin
      mode_in[1:0] = (i % 2 == 0) ? 2'd2 : 2'd3;
      @(negedge clk);
    end
    mode_in = '0;
    @(negedge clk);
    chk("R5", "fcnt_wrap", int'(chan_word[17:12]), 70 % 64);
    // R7 directed: short-frame with every enable off except master
    en_ch = 3'b111; frm_start = 3'b010; pix_left = 3'b010;
    @(negedge clk);
    frm_start = '0; pix_left = '0;
    @(negedge clk);
    chk("R7", "sfrm_always", int'(ch_irq), 3'b010);
    // R10 directed: clear together with a new underflow event
    clr_all = 1; fifo_rd = 3'b001; fifo_empty = 3'b001;
    @(negedge clk);
    clr_all = 0; fifo_rd = '0; fifo_empty = '0;
    chk("R10", "uflow_survives", int'(st_uflow), 3'b001);
    chk("R10", "sfrm_cleared", int'(st_sfrm), 0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      frm_start = rb(10); ln_start = rb(10); pix_left = rb(50);
      fifo_rd = rb(20); fifo_empty = rb(30); fifo_full = rb(30); line_done = rb(20);
      for (int c = 0; c < NCH; c++) begin
        line_num[LW*c +: LW] = LW'($urandom % 4);
        if (($urandom % 4) == 0) mode_in[2*c +: 2] = 2'($urandom % 4);
        else if (mode_in[2*c +: 2] == 2'd2 && ($urandom % 3) == 0) mode_in[2*c +: 2] = 2'd3;
      end
      if (i % 200 == 0) begin
        en_eof = rb(50); en_eoln = rb(50); en_err = rb(50); en_ch = rb(70);
      end
      dma_id_err = (($urandom % 50) == 0);
      bresp_vld = (($urandom % 8) == 0);
      bresp = 2'($urandom % 4);
      slv_rd_err = (($urandom % 60) == 0);
      slv_wr_err = (($urandom % 60) == 0);
      clr_all = (($urandom % 16) == 0);
      @(negedge clk);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule